// File: doc/BRIEF.md
# Two-Agent MOESI Coherence Tracker

This block sits inside a host bridge that connects two processor caches, each over its own point-to-point request port. For a small, parameterized set of tracked lines it keeps the coherence state that each agent holds. The states are Modified, Owned, Exclusive, Shared and Invalid. The block serves read, read-for-ownership and eviction requests from both ports. It decides whether data comes from memory, from the peer cache through the bridge, or from nowhere. It also decides whether memory must be read or written back.

A dirty line that the peer asks for moves cache-to-cache. It stays dirty in the supplier, which drops to Owned and keeps the duty to write the line back. Memory is not updated first. Both ports may present a request in the same cycle, and neither waits on the other. When both requests name the same line, they are applied in round-robin order within that cycle, and the second sees the result of the first. A lookup port shows the stored state of any tracked line for both agents.

Top module: `moesi_pair_tracker`

## Requirements
- R1: After reset every tracked line is Invalid in both agents and no response or memory request is raised. The lookup port returns each agent's state with the encoding Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4, and `resp_state_o` uses the same encoding. Request codes are read=0, read-for-ownership=1, evict=2 and no-operation=3.
- R2: A read that finds the line Invalid in both agents raises a memory read and leaves the requester Exclusive. The data source is reported as memory. Source codes are none=0, memory=1, peer=2. Every response appears exactly one cycle after its request.
- R3: A read by an Invalid requester whose peer holds the line Exclusive or Shared leaves both agents Shared. The source is the peer and no memory request is raised.
- R4: A read by an Invalid requester whose peer holds the line Modified moves the data from the peer. The peer becomes Owned and the requester Shared, with no memory access. If the peer already holds the line Owned, it stays Owned.
- R5: A read-for-ownership by an Invalid requester leaves the requester Modified and the peer Invalid. The source is the peer if the peer held any valid copy, otherwise memory with a memory read.
- R6: A read-for-ownership by a requester holding Shared, Owned or Exclusive upgrades it to Modified and invalidates the peer, with source none and no memory request. A requester already Modified is unchanged.
- R7: A read that hits a valid local copy, or a no-operation request, changes no state, reports source none and raises no memory request.
- R8: Evicting an Owned or Modified line raises a memory writeback. Evicting an Exclusive or Shared line is silent. Evicting an Invalid line does nothing. In every case the requester ends Invalid.
- R9: Same-cycle requests from both ports to one line are applied in order. Port 0 goes first at the first such collision, and priority alternates after each one. The second request sees the first one's result, and no line is ever Modified in both agents.
- R10: Same-cycle requests from both ports to different lines are handled independently. Each gets the result it would get alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 2 | Request present, one bit per port |
| req_op_i | input | 2x2 | Request code per port |
| req_line_i | input | 2xLW | Tracked line index per port |
| resp_valid_o | output | 2 | Response present per port |
| resp_state_o | output | 2x3 | Requester's state after the request |
| resp_src_o | output | 2x2 | Where the requester's data comes from |
| mem_rd_o | output | 2 | Memory read needed for that port's request |
| mem_wb_o | output | 2 | Memory writeback needed for that port's request |
| mem_line_o | output | 2xLW | Line of that port's response and memory request |
| qry_line_i | input | LW | Line to look up |
| qry_state_o | output | 2x3 | Stored state of the looked-up line, per agent |

## Verification
Every response, source code and memory request is registered, so it is due one cycle after the request. The state table is written on that same edge, so the lookup port shows the new state at the same point. The bench drives inputs on the falling edge and samples one falling edge later. It then reads the lookup port combinationally before driving the next request. The sweeps run every three-request sequence on one line from both ports, followed by a long pseudo-random mix with frequent same-line collisions. They compare against a state model kept in the bench.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } cst_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_RFO   = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } cop_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_PEER = 2'd2
    } csrc_e;

    function automatic logic is_dirty(cst_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction
endpackage

// File: rtl/mc_xact.sv
// Resolves one request against the requester's and peer's current states.
module mc_xact
    import mc_pkg::*;
(
    input  logic  act_i,
    input  cop_e  op_i,
    input  cst_e  own_i,
    input  cst_e  peer_i,
    output cst_e  own_o,
    output cst_e  peer_o,
    output csrc_e src_o,
    output logic  mem_rd_o,
    output logic  mem_wb_o
);
    always_comb begin
        own_o    = own_i;
        peer_o   = peer_i;
        src_o    = SRC_NONE;
        mem_rd_o = 1'b0;
        mem_wb_o = 1'b0;
        if (act_i) begin
            case (op_i)
                OP_RD: begin
                    if (own_i == ST_I) begin
                        case (peer_i)
                            ST_I: begin
                                own_o    = ST_E;
                                src_o    = SRC_MEM;
                                mem_rd_o = 1'b1;
                            end
                            ST_M, ST_O: begin
                                own_o  = ST_S;
                                peer_o = ST_O;
                                src_o  = SRC_PEER;
                            end
                            default: begin
                                own_o  = ST_S;
                                peer_o = ST_S;
                                src_o  = SRC_PEER;
                            end
                        endcase
                    end
                end
                OP_RFO: begin
                    if (own_i == ST_I) begin
                        own_o  = ST_M;
                        peer_o = ST_I;
                        if (peer_i == ST_I) begin
                            src_o    = SRC_MEM;
                            mem_rd_o = 1'b1;
                        end else begin
                            src_o = SRC_PEER;
                        end
                    end else if (own_i != ST_M) begin
                        own_o  = ST_M;
                        peer_o = ST_I;
                    end
                end
                OP_EVICT: begin
                    mem_wb_o = is_dirty(own_i);
                    own_o    = ST_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mc_dir.sv
// Per-line, per-agent state store with two ordered write slots.
module mc_dir
    import mc_pkg::*;
#(
    parameter int NLINES = 4,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wa_en_i,
    input  logic [LW-1:0]                wa_line_i,
    input  logic [1:0][2:0]              wa_st_i,
    input  logic                         wb_en_i,
    input  logic [LW-1:0]                wb_line_i,
    input  logic [1:0][2:0]              wb_st_i,
    output logic [NLINES-1:0][1:0][2:0]  tbl_o
);
    logic [NLINES-1:0][1:0][2:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wa_en_i) st_d[wa_line_i] = wa_st_i;
        if (wb_en_i) st_d[wb_line_i] = wb_st_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tbl_o = st_q;

    for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
        assert_no_dual_mod_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(st_q[g][0] == ST_M && st_q[g][1] == ST_M))
            else $error("line %0d Modified in both agents", g);
        assert_excl_agent0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q[g][0] == ST_M || st_q[g][0] == ST_E) |-> st_q[g][1] == ST_I)
            else $error("line %0d: agent0 exclusive while agent1 holds a copy", g);
        assert_excl_agent1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q[g][1] == ST_M || st_q[g][1] == ST_E) |-> st_q[g][0] == ST_I)
            else $error("line %0d: agent1 exclusive while agent0 holds a copy", g);
        assert_single_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(st_q[g][0] == ST_O && st_q[g][1] == ST_O))
            else $error("line %0d Owned in both agents", g);
    end
endmodule

// File: rtl/mc_arb.sv
// Picks which port is applied first; alternates after each same-line collision.
module mc_arb (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] valid_i,
    input  logic       same_line_i,
    output logic       win_o,
    output logic       both_o
);
    logic rr_d, rr_q;

    always_comb begin
        both_o = valid_i[0] & valid_i[1];
        rr_d   = rr_q;
        if (both_o) begin
            win_o = rr_q;
            if (same_line_i) rr_d = ~rr_q;
        end else begin
            win_o = valid_i[1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rr_q <= 1'b0;
        else         rr_q <= rr_d;
    end

    assert_rr_flip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i == 2'b11 && same_line_i) |=> rr_q != $past(rr_q))
        else $error("priority did not alternate after a collision");
    assert_rr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_i == 2'b11 && same_line_i) |=> $stable(rr_q))
        else $error("priority moved without a collision");
endmodule

// File: rtl/moesi_pair_tracker.sv
module moesi_pair_tracker
    import mc_pkg::*;
#(
    parameter int NLINES = 4,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [1:0]           req_valid_i,
    input  logic [1:0][1:0]      req_op_i,
    input  logic [1:0][LW-1:0]   req_line_i,
    output logic [1:0]           resp_valid_o,
    output logic [1:0][2:0]      resp_state_o,
    output logic [1:0][1:0]      resp_src_o,
    output logic [1:0]           mem_rd_o,
    output logic [1:0]           mem_wb_o,
    output logic [1:0][LW-1:0]   mem_line_o,
    input  logic [LW-1:0]        qry_line_i,
    output logic [1:0][2:0]      qry_state_o
);
    typedef struct packed {
        logic [1:0]         vld;
        logic [1:0][2:0]    st;
        logic [1:0][1:0]    src;
        logic [1:0]         rd;
        logic [1:0]         wb;
        logic [1:0][LW-1:0] ln;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic [NLINES-1:0][1:0][2:0] tbl;
    logic win, lose, both, same_line, collide;

    // slot A: first-applied request, slot B: second
    logic          act_a, act_b;
    logic [LW-1:0] line_a, line_b;
    cop_e          op_a, op_b;
    cst_e          own_a, peer_a, own_b, peer_b;
    cst_e          own_na, peer_na, own_nb, peer_nb;
    csrc_e         src_a, src_b;
    logic          rd_a, wb_a, rd_b, wb_b;
    logic [1:0][2:0] wa_st, wb_st;

    assign same_line = (req_line_i[0] == req_line_i[1]);

    mc_arb u_arb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .valid_i     (req_valid_i),
        .same_line_i (same_line),
        .win_o       (win),
        .both_o      (both)
    );

    assign lose = ~win;

    always_comb begin
        act_a  = req_valid_i[win];
        line_a = req_line_i[win];
        op_a   = cop_e'(req_op_i[win]);
        own_a  = cst_e'(tbl[line_a][win]);
        peer_a = cst_e'(tbl[line_a][lose]);
    end

    mc_xact u_xa (
        .act_i (act_a), .op_i (op_a), .own_i (own_a), .peer_i (peer_a),
        .own_o (own_na), .peer_o (peer_na), .src_o (src_a),
        .mem_rd_o (rd_a), .mem_wb_o (wb_a)
    );

    always_comb begin
        act_b   = both;
        line_b  = req_line_i[lose];
        op_b    = cop_e'(req_op_i[lose]);
        collide = both && same_line;
        if (collide) begin
            own_b  = peer_na;
            peer_b = own_na;
        end else begin
            own_b  = cst_e'(tbl[line_b][lose]);
            peer_b = cst_e'(tbl[line_b][win]);
        end
    end

    mc_xact u_xb (
        .act_i (act_b), .op_i (op_b), .own_i (own_b), .peer_i (peer_b),
        .own_o (own_nb), .peer_o (peer_nb), .src_o (src_b),
        .mem_rd_o (rd_b), .mem_wb_o (wb_b)
    );

    always_comb begin
        wa_st       = '0;
        wa_st[win]  = own_na;
        wa_st[lose] = peer_na;
        wb_st       = '0;
        wb_st[lose] = own_nb;
        wb_st[win]  = peer_nb;

        rsp_d = '0;
        if (act_a) begin
            rsp_d.vld[win] = 1'b1;
            rsp_d.st[win]  = own_na;
            rsp_d.src[win] = src_a;
            rsp_d.rd[win]  = rd_a;
            rsp_d.wb[win]  = wb_a;
            rsp_d.ln[win]  = line_a;
        end
        if (act_b) begin
            rsp_d.vld[lose] = 1'b1;
            rsp_d.st[lose]  = own_nb;
            rsp_d.src[lose] = src_b;
            rsp_d.rd[lose]  = rd_b;
            rsp_d.wb[lose]  = wb_b;
            rsp_d.ln[lose]  = line_b;
        end
    end

    mc_dir #(.NLINES(NLINES)) u_dir (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wa_en_i   (act_a),
        .wa_line_i (line_a),
        .wa_st_i   (wa_st),
        .wb_en_i   (act_b),
        .wb_line_i (line_b),
        .wb_st_i   (wb_st),
        .tbl_o     (tbl)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rsp_q <= '0;
        else         rsp_q <= rsp_d;
    end

    assign resp_valid_o = rsp_q.vld;
    assign resp_state_o = rsp_q.st;
    assign resp_src_o   = rsp_q.src;
    assign mem_rd_o     = rsp_q.rd;
    assign mem_wb_o     = rsp_q.wb;
    assign mem_line_o   = rsp_q.ln;
    assign qry_state_o  = tbl[qry_line_i];

    for (genvar p = 0; p < 2; p++) begin : g_port_chk
        assert_resp_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            req_valid_i[p] |=> resp_valid_o[p])
            else $error("port %0d response missing one cycle after request", p);
        assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !req_valid_i[p] |=> !resp_valid_o[p] && !mem_rd_o[p] && !mem_wb_o[p])
            else $error("port %0d activity without a request", p);
        assert_memrd_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            mem_rd_o[p] |-> resp_src_o[p] == SRC_MEM && resp_state_o[p] != ST_I)
            else $error("port %0d memory read with wrong source/state", p);
        assert_fwd_nomem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            resp_src_o[p] == SRC_PEER |-> !mem_rd_o[p] && !mem_wb_o[p])
            else $error("port %0d peer forward touched memory", p);
        assert_wb_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            mem_wb_o[p] |-> resp_state_o[p] == ST_I && resp_src_o[p] == SRC_NONE)
            else $error("port %0d writeback without ending Invalid", p);
    end
endmodule

// File: tb/sim_moesi_pair_tracker.sv
module sim_moesi_pair_tracker;
    localparam int NL = 4;
    localparam int LW = $clog2(NL);
    localparam time TCLK = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]         req_valid = '0;
    logic [1:0][1:0]    req_op = '0;
    logic [1:0][LW-1:0] req_line = '0;
    logic [1:0]         resp_valid;
    logic [1:0][2:0]    resp_state;
    logic [1:0][1:0]    resp_src;
    logic [1:0]         mem_rd, mem_wb;
    logic [1:0][LW-1:0] mem_line;
    logic [LW-1:0]      qry_line = '0;
    logic [1:0][2:0]    qry_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mst [NL][2];
    int rr = 0;

    always #(TCLK/2) clk = ~clk;

    moesi_pair_tracker #(.NLINES(NL)) u0 (
        .clk_i (clk), .rst_ni (rst_n),
        .req_valid_i (req_valid), .req_op_i (req_op), .req_line_i (req_line),
        .resp_valid_o (resp_valid), .resp_state_o (resp_state), .resp_src_o (resp_src),
        .mem_rd_o (mem_rd), .mem_wb_o (mem_wb), .mem_line_o (mem_line),
        .qry_line_i (qry_line), .qry_state_o (qry_state)
    );

    task automatic check(input bit ok, input string tg, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tg, what, act, exp);
        end
    endtask

    // Requirement-level reference: states I=0 S=1 E=2 O=3 M=4, src none=0 mem=1 peer=2
    task automatic mstep(input int p, input int op, input int l,
                         output int st, output int src, output int rd, output int wb, output string tg);
        int own = mst[l][p];
        int peer = mst[l][1-p];
        src = 0; rd = 0; wb = 0; tg = "R7";
        case (op)
            0: if (own == 0) begin
                if (peer == 0)      begin own = 2; src = 1; rd = 1; tg = "R2"; end
                else if (peer >= 3) begin own = 1; peer = 3; src = 2; tg = "R4"; end
                else                begin own = 1; peer = 1; src = 2; tg = "R3"; end
            end
            1: begin
                if (own == 0) begin
                    src = (peer == 0) ? 1 : 2; rd = (peer == 0); tg = "R5";
                    own = 4; peer = 0;
                end else begin
                    tg = "R6";
                    if (own != 4) begin own = 4; peer = 0; end
                end
            end
            2: begin wb = (own >= 3); own = 0; tg = "R8"; end
            default: tg = "R7";
        endcase
        mst[l][p] = own;
        mst[l][1-p] = peer;
        st = own;
    endtask

    task automatic step(input bit v0, input int o0, input int l0,
                        input bit v1, input int o1, input int l1);
        int est[2], esrc[2], erd[2], ewb[2];
        string etg[2];
        int vv[2], oo[2], ll[2];
        int w;
        bit same;
        vv[0] = v0; vv[1] = v1; oo[0] = o0; oo[1] = o1; ll[0] = l0; ll[1] = l1;
        @(negedge clk);
        req_valid = {v1, v0};
        req_op[0] = o0[1:0]; req_op[1] = o1[1:0];
        req_line[0] = l0[LW-1:0]; req_line[1] = l1[LW-1:0];
        same = v0 && v1 && (l0 == l1);
        w = (v0 && v1) ? rr : (v0 ? 0 : 1);
        for (int k = 0; k < 2; k++) begin
            int p = (k == 0) ? w : 1 - w;
            etg[p] = "R1";
            if (vv[p] != 0) begin
                mstep(p, oo[p], ll[p], est[p], esrc[p], erd[p], ewb[p], etg[p]);
                if (v0 && v1) etg[p] = {etg[p], same ? "/R9" : "/R10"};
            end
        end
        if (same) rr = 1 - rr;
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            int act, exp;
            act = {resp_valid[p], resp_state[p], resp_src[p], mem_rd[p], mem_wb[p]};
            if (vv[p] != 0) begin
                exp = {1'b1, est[p][2:0], esrc[p][1:0], erd[p][0], ewb[p][0]};
                check(act == exp, etg[p], $sformatf("port%0d response", p), act, exp);
                check(mem_line[p] == ll[p][LW-1:0], etg[p], $sformatf("port%0d line", p),
                      int'(mem_line[p]), ll[p]);
            end else begin
                check(act[8] == 1'b0 && act[1:0] == 2'b00, "R1",
                      $sformatf("port%0d idle", p), act, 0);
            end
        end
        req_valid = '0;
        for (int p = 0; p < 2; p++) begin
            if (vv[p] != 0) begin
                qry_line = ll[p][LW-1:0];
                #1;
                for (int a = 0; a < 2; a++)
                    check(int'(qry_state[a]) == mst[ll[p]][a], etg[p],
                          $sformatf("line%0d agent%0d state", ll[p], a),
                          int'(qry_state[a]), mst[ll[p]][a]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int l = 0; l < NL; l++) begin mst[l][0] = 0; mst[l][1] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(resp_valid == 2'b00 && mem_rd == 2'b00 && mem_wb == 2'b00, "R1",
              "outputs after reset", {resp_valid, mem_rd, mem_wb}, 0);
        for (int l = 0; l < NL; l++) begin
            qry_line = l[LW-1:0];
            #1;
            check(qry_state == '0, "R1", $sformatf("line%0d after reset", l), int'(qry_state), 0);
        end

        // Exhaustive three-request sequences on one line, then a paired evict (R9 collision)
        for (int s = 0; s < 216; s++) begin
            int code = s;
            int ln = s % NL;
            for (int k = 0; k < 3; k++) begin
                int pick = code % 6;
                code = code / 6;
                if (pick < 3) step(1, pick, ln, 0, 0, 0);
                else          step(0, 0, 0, 1, pick - 3, ln);
            end
            step(1, 2, ln, 1, 2, ln);
        end

        // Pseudo-random mix: collisions, different-line pairs, no-ops
        for (int i = 0; i < 3000; i++) begin
            bit v0, v1;
            int o0, o1, l0, l1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            v0 = lf[0] | lf[7];
            v1 = lf[1] | lf[8];
            o0 = int'(lf[3:2]);
            o1 = int'(lf[5:4]);
            l0 = int'(lf[6]);
            l1 = lf[9] ? int'(lf[6]) : int'(lf[11:10]);
            step(v0, o0, l0, v1, o1, l1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule